// File: doc/BRIEF.md
# Program Counter with Next-Address Selection and Exception Vectors

This block holds the program counter of a single-cycle 32-bit processor and chooses, each clock, where the next instruction is fetched from. The counter stores only the word part of the address, because the two low bits are always zero. A 3-bit select code from the instruction decoder picks one of several sources. The sources are the sequential address, a conditional branch taken on the ALU zero flag, a direct jump, a target read from a register, a fixed vector for illegal instructions and a fixed vector for interrupts. An interrupt request input overrides the select code. The reset vector is loaded while reset is held.

The block gives the current PC to the instruction memory. It also gives PC+4, which the register file stores as the return address when a link instruction executes. The branch target has its own adder. The ALU is not used for it, because the ALU is busy subtracting the two compared registers in the same cycle.

Top module: `pc_next_select`

## Requirements
- R1: While `rst_n` is low, `pc_o` equals the reset vector (default 0x00000000), and it stays there until the first rising clock edge with `rst_n` high.
- R2: Select code 0 loads `pc_o + 4` at the next rising edge. The sum wraps modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R3: `pc_plus4_o` always equals `pc_o + 4` modulo 2^32.
- R4: Select code 1 (branch if equal) loads `pc_o + 4 + imm_i*4` when `zero_i` is 1, and `pc_o + 4` when `zero_i` is 0. `imm_i` is a two's-complement sign-extended offset.
- R5: Select code 2 (branch if not equal) loads `pc_o + 4 + imm_i*4` when `zero_i` is 0, and `pc_o + 4` when `zero_i` is 1.
- R6: Select code 3 (jump) loads a 32-bit value built from three parts. Bits 31:28 are bits 31:28 of `pc_o + 4`. The next bits are the 26-bit `jfield_i`. The low two bits are 00.
- R7: Select code 4 (register target) loads `reg_tgt_i` with bits 1:0 forced to 00. The low two bits of the register value have no effect.
- R8: Select code 5 loads the illegal-instruction vector (default 0x00000040).
- R9: Select code 6 loads the interrupt vector (default 0x00000080).
- R10: When `irq_i` is 1, the interrupt vector is loaded whatever the select code, zero flag or targets are.
- R11: Select code 7 is reserved and behaves exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Interrupt request, overrides the select code |
| pc_sel_i | input | 3 | Next-address select code |
| imm_i | input | 32 | Sign-extended branch offset in words |
| jfield_i | input | 26 | Jump target field of the instruction |
| reg_tgt_i | input | 32 | Register-indirect jump target |
| zero_i | input | 1 | ALU zero flag |
| pc_o | output | 32 | Current instruction address |
| pc_plus4_o | output | 32 | Current address plus 4, for link writes |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 26-bit jump field and vectors at 0x0, 0x40 and 0x80. With these values, a register jump can place the PC at the top of the address space, and the wrap of the sequential adder and of the PC+4 output is then tested. Negative random offsets move branches backwards, and random jump fields cover all the upper-bit merges. Interrupt requests are applied together with each select code.

// File: rtl/pc_sel_pkg.sv
package pc_sel_pkg;
  typedef enum logic [2:0] {
    SEL_SEQ   = 3'd0,
    SEL_BEQ   = 3'd1,
    SEL_BNE   = 3'd2,
    SEL_JUMP  = 3'd3,
    SEL_REG   = 3'd4,
    SEL_ILLOP = 3'd5,
    SEL_INTR  = 3'd6,
    SEL_RSVD  = 3'd7
  } pc_sel_e;
endpackage

// File: rtl/pc_word_reg.sv
module pc_word_reg #(
  parameter int            PW     = 30,
  parameter logic [PW-1:0] RST_W  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] d_i,
  output logic [PW-1:0] q_o
);
  logic [PW-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RST_W;
    else        q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/pc_targets.sv
module pc_targets #(
  parameter int XLEN = 32,
  parameter int JW   = 26,
  localparam int PW  = XLEN - 2
) (
  input  logic [PW-1:0]   pc_w_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [JW-1:0]   jfield_i,
  output logic [PW-1:0]   seq_w_o,
  output logic [PW-1:0]   br_w_o,
  output logic [PW-1:0]   jmp_w_o
);
  logic [PW-1:0] seq_w;

  // Incrementer on the word address (adds 4 bytes).
  assign seq_w   = pc_w_i + PW'(1);
  // Dedicated branch adder; the word offset is the x4 shift by wiring.
  assign br_w_o  = seq_w + imm_i[PW-1:0];
  // Direct jump keeps the upper bits of the sequential address.
  assign jmp_w_o = {seq_w[PW-1:JW], jfield_i};
  assign seq_w_o = seq_w;
endmodule

// File: rtl/pc_mux.sv
module pc_mux
  import pc_sel_pkg::*;
#(
  parameter int            PW      = 30,
  parameter logic [PW-1:0] ILL_W   = '0,
  parameter logic [PW-1:0] INTR_W  = '0
) (
  input  pc_sel_e       sel_i,
  input  logic          irq_i,
  input  logic          zero_i,
  input  logic [PW-1:0] seq_w_i,
  input  logic [PW-1:0] br_w_i,
  input  logic [PW-1:0] jmp_w_i,
  input  logic [PW-1:0] reg_w_i,
  output logic [PW-1:0] nxt_w_o
);
  always_comb begin
    nxt_w_o = seq_w_i;
    if (irq_i) begin
      nxt_w_o = INTR_W;
    end else begin
      unique case (sel_i)
        SEL_BEQ:   nxt_w_o = zero_i ? br_w_i : seq_w_i;
        SEL_BNE:   nxt_w_o = zero_i ? seq_w_i : br_w_i;
        SEL_JUMP:  nxt_w_o = jmp_w_i;
        SEL_REG:   nxt_w_o = reg_w_i;
        SEL_ILLOP: nxt_w_o = ILL_W;
        SEL_INTR:  nxt_w_o = INTR_W;
        SEL_SEQ,
        SEL_RSVD:  nxt_w_o = seq_w_i;
        default:   nxt_w_o = seq_w_i;
      endcase
    end
  end
endmodule

// File: rtl/pc_next_select.sv
module pc_next_select
  import pc_sel_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              JW        = 26,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0000,
  parameter logic [XLEN-1:0] ILL_VEC   = 32'h0000_0040,
  parameter logic [XLEN-1:0] INTR_VEC  = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_i,
  input  logic [2:0]      pc_sel_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [JW-1:0]   jfield_i,
  input  logic [XLEN-1:0] reg_tgt_i,
  input  logic            zero_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] pc_plus4_o
);
  localparam int            PW     = XLEN - 2;
  localparam logic [PW-1:0] RST_W  = RESET_VEC[XLEN-1:2];
  localparam logic [PW-1:0] ILL_W  = ILL_VEC[XLEN-1:2];
  localparam logic [PW-1:0] INTR_W = INTR_VEC[XLEN-1:2];

  logic [PW-1:0] pc_w, nxt_w, seq_w, br_w, jmp_w;
  pc_sel_e       sel;

  assign sel = pc_sel_e'(pc_sel_i);

  pc_targets #(.XLEN(XLEN), .JW(JW)) u_targets (
    .pc_w_i   (pc_w),
    .imm_i    (imm_i),
    .jfield_i (jfield_i),
    .seq_w_o  (seq_w),
    .br_w_o   (br_w),
    .jmp_w_o  (jmp_w)
  );

  pc_mux #(.PW(PW), .ILL_W(ILL_W), .INTR_W(INTR_W)) u_mux (
    .sel_i   (sel),
    .irq_i   (irq_i),
    .zero_i  (zero_i),
    .seq_w_i (seq_w),
    .br_w_i  (br_w),
    .jmp_w_i (jmp_w),
    .reg_w_i (reg_tgt_i[XLEN-1:2]),
    .nxt_w_o (nxt_w)
  );

  pc_word_reg #(.PW(PW), .RST_W(RST_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (nxt_w),
    .q_o   (pc_w)
  );

  assign pc_o       = {pc_w, 2'b00};
  assign pc_plus4_o = {seq_w, 2'b00};

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && sel == SEL_SEQ) |=> pc_o == $past(pc_o) + XLEN'(4));

  // R4
  beq_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && sel == SEL_BEQ && !zero_i) |=> pc_o == $past(pc_plus4_o));

  // R5
  bne_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && sel == SEL_BNE && zero_i) |=> pc_o == $past(pc_plus4_o));

  // R7
  reg_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && sel == SEL_REG) |=> pc_o == {$past(reg_tgt_i[XLEN-1:2]), 2'b00});

  // R8
  illop_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && sel == SEL_ILLOP) |=> pc_o == ILL_VEC);

  // R10
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |=> pc_o == INTR_VEC);

  // R11
  rsvd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_i && sel == SEL_RSVD) |=> pc_o == $past(pc_o) + XLEN'(4));
endmodule

// File: tb/test_pc_next_select.sv
module test_pc_next_select;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq;
  logic [2:0]  sel;
  logic [31:0] imm;
  logic [25:0] jf;
  logic [31:0] tgt;
  logic        zero;
  logic [31:0] pc, pc4;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] model;

  pc_next_select i_pc_next_select (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .pc_sel_i(sel), .imm_i(imm),
    .jfield_i(jf), .reg_tgt_i(tgt), .zero_i(zero), .pc_o(pc), .pc_plus4_o(pc4)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_next(logic [31:0] p, logic [2:0] s, logic i,
      logic z, logic [31:0] im, logic [25:0] j, logic [31:0] t);
    logic [31:0] p4;
    p4 = p + 32'd4;
    if (i) return 32'h80;
    case (s)
      3'd1: return z ? p4 + (im << 2) : p4;
      3'd2: return z ? p4 : p4 + (im << 2);
      3'd3: return {p4[31:28], j, 2'b00};
      3'd4: return {t[31:2], 2'b00};
      3'd5: return 32'h40;
      3'd6: return 32'h80;
      default: return p4;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] s, logic i);
    if (i) return "R10";
    case (s)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      3'd7: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs for one cycle and checks the result.
  task automatic step(logic [2:0] s, logic i, logic z, logic [31:0] im,
      logic [25:0] j, logic [31:0] t);
    logic [31:0] e;
    e = exp_next(model, s, i, z, im, j, t);
    sel = s; irq = i; zero = z; imm = im; jf = j; tgt = t;
    @(posedge clk);
    @(negedge clk);
    model = e;
    check(tag_of(s, i), pc, model);
    check("R3", pc4, model + 32'd4);
  endtask

  function automatic logic [31:0] sx16(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; irq = 0; sel = 0; imm = 0; jf = 0; tgt = 0; zero = 0;
    #3;
    check("R1", pc, 32'h0);
    repeat (2) @(negedge clk);
    check("R1", pc, 32'h0);
    check("R3", pc4, 32'h4);
    rst_n = 1'b1;
    model = 32'h0;

    // Directed corner cases
    step(3'd0, 0, 0, 0, 0, 0);                       // R2
    step(3'd4, 0, 0, 0, 0, 32'h0000_1237);           // R7 low bits dropped
    step(3'd1, 0, 1, sx16(16'hFFFC), 0, 0);          // R4 backward taken
    step(3'd1, 0, 0, sx16(16'h0010), 0, 0);          // R4 not taken
    step(3'd2, 0, 1, sx16(16'h0010), 0, 0);          // R5 not taken
    step(3'd2, 0, 0, sx16(16'h0008), 0, 0);          // R5 taken
    step(3'd4, 0, 0, 0, 0, 32'hF000_0100);           // R7
    step(3'd3, 0, 0, 0, 26'h3FF_FFFF, 0);            // R6 upper bits kept
    step(3'd4, 0, 0, 0, 0, 32'hFFFF_FFFE);           // R7 to top
    step(3'd0, 0, 0, 0, 0, 0);                       // R2 wrap to 0
    step(3'd5, 0, 0, 0, 0, 0);                       // R8
    step(3'd6, 0, 0, 0, 0, 0);                       // R9
    step(3'd7, 0, 0, 0, 0, 0);                       // R11
    step(3'd3, 1, 0, 0, 26'h155_5555, 0);            // R10 overrides jump
    step(3'd1, 1, 1, sx16(16'h0100), 0, 0);          // R10 overrides branch

    // Reset in mid-run
    step(3'd4, 0, 0, 0, 0, 32'h1234_5678);
    rst_n = 1'b0;
    #2;
    check("R1", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    model = 32'h0;

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s;
      int w;
      w = $urandom_range(0, 99);
      if (w < 30) s = 3'd0;
      else if (w < 45) s = 3'd1;
      else if (w < 60) s = 3'd2;
      else if (w < 70) s = 3'd3;
      else if (w < 82) s = 3'd4;
      else if (w < 88) s = 3'd5;
      else if (w < 94) s = 3'd6;
      else s = 3'd7;
      step(s, ($urandom_range(0, 19) == 0), 1'($urandom), sx16(16'($urandom)),
           26'($urandom), $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule